// File: doc/BRIEF.md
# Real-Time Counter with Alarm Interrupts

This peripheral keeps time from a slow reference clock. A programmable prescaler divides the reference down to a tick, and each tick advances a free-running 32-bit counter. Two compare registers watch the counter. Each one raises an event flag on the tick that moves the counter onto its value. The periodic tick raises its own event flag. Each flag has its own enable bit, and one registered interrupt line reports any flag whose enable bit is set.

Software reaches the block over a simple synchronous bus. The bus has an address, a write strobe, write data and combinational read data. The counter can be loaded at any time. A scratch word next to the counter keeps a software-maintained epoch value, because a counter wrap raises no flag of its own. A two-bit clock-select field is stored and read back. Software programs it to 3 to select the crystal.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset, every register reads zero, the interrupt output is low and the prescaler count restarts from zero.
- R2: With divider value D (offset 0x0C), the counter advances once every 2*(D+1) clock cycles. A write to the divider restarts the prescaler phase, so the first tick after it falls 2*(D+1) cycles after the write edge.
- R3: The counter (0x00), compare A (0x04), compare B (0x18) and scratch (0x40) read back what was last written to them. The scratch word changes only when it is written. A counter write takes priority over a tick in the same cycle.
- R4: The counter wraps from 0xFFFFFFFF to 0 with no wrap flag. A compare flag is raised only when the value after the wrap equals that compare register.
- R5: In the status word (0x08), bit 0 sets when a tick moves the counter onto compare A, bit 4 sets when a tick moves it onto compare B, and bit 1 sets on every tick. These flags set whether or not their enable bits are set.
- R6: Writing 1 to status bit 0, 1 or 4 clears that flag. Writing 0 leaves the flag unchanged. If a set and a clear reach the same flag in the same cycle, the set wins.
- R7: Status bits 2, 3 and 6 are the enables for compare A, the tick and compare B. They are stored as written and read back. Bits 5 and 7 to 31 read zero.
- R8: The interrupt output is the OR of each flag ANDed with its enable bit, registered once. It follows a flag or enable change by one cycle.
- R9: The clock-select register (0x1C) stores the low two bits of the write data. The upper bits read zero, and a write of 3 reads back 3.
- R10: Unmapped offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_we_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Assertions check the following on every cycle: the counter steps by exactly one on a tick and holds otherwise, including the wrap to zero; no tick follows a prescaler restart; a flag set always wins over a clear in the same cycle; the interrupt equals the previous cycle's enabled flags; and the scratch and clock-select registers hold unless they are written. The tick rate for a sweep of divider values, the exact phase after a divider write, and the cycle in which each compare flag first appears can be shown only by the bench scenarios. The same holds for the read-back bit layout of the status word and the zero reads at unmapped offsets.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int DATA_W = 32;

    // register byte offsets (software decodes these)
    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_CMP_A   = 8'h04;
    localparam logic [7:0] OFF_STATUS  = 8'h08;
    localparam logic [7:0] OFF_DIVIDER = 8'h0C;
    localparam logic [7:0] OFF_CMP_B   = 8'h18;
    localparam logic [7:0] OFF_CLKSEL  = 8'h1C;
    localparam logic [7:0] OFF_SCRATCH = 8'h40;

    // event indices inside the flag and enable vectors
    localparam int NUM_EV   = 3;
    localparam int EV_CMP_A = 0;
    localparam int EV_TICK  = 1;
    localparam int EV_CMP_B = 2;

    // bit positions in the status word
    localparam int ST_FLAG_A    = 0;
    localparam int ST_FLAG_TICK = 1;
    localparam int ST_EN_A      = 2;
    localparam int ST_EN_TICK   = 3;
    localparam int ST_FLAG_B    = 4;
    localparam int ST_EN_B      = 6;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    function automatic logic [DATA_W-1:0] pack_status(input ev_vec_t flags, input ev_vec_t en);
        logic [DATA_W-1:0] s;
        s               = '0;
        s[ST_FLAG_A]    = flags[EV_CMP_A];
        s[ST_FLAG_TICK] = flags[EV_TICK];
        s[ST_FLAG_B]    = flags[EV_CMP_B];
        s[ST_EN_A]      = en[EV_CMP_A];
        s[ST_EN_TICK]   = en[EV_TICK];
        s[ST_EN_B]      = en[EV_CMP_B];
        return s;
    endfunction

    function automatic ev_vec_t flag_bits(input logic [DATA_W-1:0] w);
        ev_vec_t v;
        v[EV_CMP_A] = w[ST_FLAG_A];
        v[EV_TICK]  = w[ST_FLAG_TICK];
        v[EV_CMP_B] = w[ST_FLAG_B];
        return v;
    endfunction

    function automatic ev_vec_t enable_bits(input logic [DATA_W-1:0] w);
        ev_vec_t v;
        v[EV_CMP_A] = w[ST_EN_A];
        v[EV_TICK]  = w[ST_EN_TICK];
        v[EV_CMP_B] = w[ST_EN_B];
        return v;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    localparam int PW = DIV_W + 1;

    logic [PW-1:0] pcnt_d, pcnt_q;
    logic [PW-1:0] limit;

    // one tick per 2*(div+1) source cycles
    assign limit  = {div_i, 1'b1};
    assign tick_o = (pcnt_q == limit);

    always_comb begin
        pcnt_d = pcnt_q + 1'b1;
        if (restart_i || tick_o) begin
            pcnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

    assert_no_tick_after_restart_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o
    ) else $error("tick right after prescaler restart");

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_a_o,
    output logic             hit_b_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] step_val;
    logic             advance;

    assign step_val = st_q.count + 1'b1;
    assign advance  = tick_i && !load_i;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (tick_i) begin
            st_d.count = step_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign hit_a_o = advance && (step_val == cmp_a_i);
    assign hit_b_o = advance && (step_val == cmp_b_i);

    assert_count_step_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> count_o == CNT_W'($past(count_o) + 1'b1)
    ) else $error("counter did not step on tick");

    assert_count_hold_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o)
    ) else $error("counter moved without tick or load");

    assert_count_wrap_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && (&count_o)) |=> (count_o == '0)
    ) else $error("counter did not wrap to zero");

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flags_o
);
    logic [NUM-1:0] flags_d, flags_q;

    for (genvar i = 0; i < NUM; i++) begin : g_ev
        // set wins over a same-cycle write-one-to-clear
        always_comb begin
            flags_d[i] = (flags_q[i] && !clr_i[i]) || set_i[i];
        end

        assert_set_wins_R6: assert property (
            @(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]
        ) else $error("event flag set was lost");

        assert_clear_R6: assert property (
            @(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]
        ) else $error("event flag not cleared");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr_i,
    input  logic                              bus_we_i,
    input  logic [rtc_alarm_pkg::DATA_W-1:0]  bus_wdata_i,
    output logic [rtc_alarm_pkg::DATA_W-1:0]  bus_rdata_o,
    output logic                              irq_o
);
    import rtc_alarm_pkg::*;

    localparam int CLKSEL_W = 2;

    typedef struct packed {
        logic [DIV_W-1:0]    div;
        logic [CNT_W-1:0]    cmp_a;
        logic [CNT_W-1:0]    cmp_b;
        logic [DATA_W-1:0]   scratch;
        logic [CLKSEL_W-1:0] clksel;
        ev_vec_t             en;
        logic                irq;
    } regs_t;

    regs_t            st_d, st_q;
    logic             wr_count, wr_cmp_a, wr_cmp_b, wr_status;
    logic             wr_div, wr_clksel, wr_scratch;
    logic             tick;
    logic             hit_a, hit_b;
    logic [CNT_W-1:0] count;
    ev_vec_t          ev_set, ev_clr, flags;

    // address decode
    always_comb begin
        wr_count   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_COUNT));
        wr_cmp_a   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CMP_A));
        wr_status  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_STATUS));
        wr_div     = bus_we_i && (bus_addr_i == ADDR_W'(OFF_DIVIDER));
        wr_cmp_b   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CMP_B));
        wr_clksel  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CLKSEL));
        wr_scratch = bus_we_i && (bus_addr_i == ADDR_W'(OFF_SCRATCH));
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (st_q.div),
        .restart_i (wr_div),
        .tick_o    (tick)
    );

    rtc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (wr_count),
        .load_val_i (CNT_W'(bus_wdata_i)),
        .cmp_a_i    (st_q.cmp_a),
        .cmp_b_i    (st_q.cmp_b),
        .count_o    (count),
        .hit_a_o    (hit_a),
        .hit_b_o    (hit_b)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_CMP_A] = hit_a;
        ev_set[EV_TICK]  = tick;
        ev_set[EV_CMP_B] = hit_b;
        ev_clr           = wr_status ? flag_bits(bus_wdata_i) : '0;
    end

    rtc_event_flags #(.NUM(NUM_EV)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_set),
        .clr_i   (ev_clr),
        .flags_o (flags)
    );

    // next-state for the register file and interrupt
    always_comb begin
        st_d = st_q;
        if (wr_cmp_a)   st_d.cmp_a   = CNT_W'(bus_wdata_i);
        if (wr_cmp_b)   st_d.cmp_b   = CNT_W'(bus_wdata_i);
        if (wr_div)     st_d.div     = DIV_W'(bus_wdata_i);
        if (wr_scratch) st_d.scratch = bus_wdata_i;
        if (wr_clksel)  st_d.clksel  = bus_wdata_i[CLKSEL_W-1:0];
        if (wr_status)  st_d.en      = enable_bits(bus_wdata_i);
        st_d.irq = |(flags & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read-back mux
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFF_COUNT))   bus_rdata_o = DATA_W'(count);
        if (bus_addr_i == ADDR_W'(OFF_CMP_A))   bus_rdata_o = DATA_W'(st_q.cmp_a);
        if (bus_addr_i == ADDR_W'(OFF_STATUS))  bus_rdata_o = pack_status(flags, st_q.en);
        if (bus_addr_i == ADDR_W'(OFF_DIVIDER)) bus_rdata_o = DATA_W'(st_q.div);
        if (bus_addr_i == ADDR_W'(OFF_CMP_B))   bus_rdata_o = DATA_W'(st_q.cmp_b);
        if (bus_addr_i == ADDR_W'(OFF_CLKSEL))  bus_rdata_o = DATA_W'(st_q.clksel);
        if (bus_addr_i == ADDR_W'(OFF_SCRATCH)) bus_rdata_o = st_q.scratch;
    end

    assign irq_o = st_q.irq;

    assert_irq_raise_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (|(flags & st_q.en)) |=> irq_o
    ) else $error("interrupt missing after enabled flag");

    assert_irq_quiet_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(|(flags & st_q.en)) |=> !irq_o
    ) else $error("interrupt without enabled flag");

    assert_scratch_hold_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wr_scratch |=> $stable(st_q.scratch)
    ) else $error("scratch changed without a write");

    assert_clksel_store_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_clksel |=> st_q.clksel == $past(bus_wdata_i[CLKSEL_W-1:0])
    ) else $error("clock select not stored");

endmodule

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;
    import rtc_alarm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_timer u_rtc_alarm_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        we   = 1'b0;
        #0.5;
        d = rdata;
    endtask

    initial begin
        logic [31:0] r, c0, c1;
        bit seen;
        rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(OFF_COUNT, r);   chk("R1 count", r, 0);
        rd(OFF_CMP_A, r);   chk("R1 cmp A", r, 0);
        rd(OFF_CMP_B, r);   chk("R1 cmp B", r, 0);
        rd(OFF_STATUS, r);  chk("R1 status", r, 0);
        rd(OFF_DIVIDER, r); chk("R1 divider", r, 0);
        rd(OFF_SCRATCH, r); chk("R1 scratch", r, 0);
        rd(OFF_CLKSEL, r);  chk("R1 clksel", r, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 rate sweep over divider values
        for (int d = 0; d < 6; d++) begin
            wr(OFF_DIVIDER, 32'(d));
            rd(OFF_DIVIDER, r); chk("R2 divider readback", r, 32'(d));
            repeat (3) @(negedge clk);
            rd(OFF_COUNT, c0);
            repeat (3 * 2 * (d + 1)) @(negedge clk);
            rd(OFF_COUNT, c1);
            chk("R2 tick rate", c1 - c0, 3);
        end

        // R2 restart phase: period 10, first tick 10 cycles after write
        wr(OFF_DIVIDER, 4);
        rd(OFF_COUNT, c0);
        repeat (9) @(negedge clk);
        rd(OFF_COUNT, c1); chk("R2 no early tick", c1 - c0, 0);
        @(negedge clk);
        rd(OFF_COUNT, c1); chk("R2 tick on phase", c1 - c0, 1);

        // R3 read-back of loadable registers
        wr(OFF_DIVIDER, 100);
        wr(OFF_COUNT, 32'h1234_5678);
        rd(OFF_COUNT, r);   chk("R3 count load", r, 32'h1234_5678);
        wr(OFF_CMP_A, 32'hDEAD_0001);
        rd(OFF_CMP_A, r);   chk("R3 cmp A", r, 32'hDEAD_0001);
        wr(OFF_CMP_B, 32'h0BAD_F00D);
        rd(OFF_CMP_B, r);   chk("R3 cmp B", r, 32'h0BAD_F00D);
        for (int b = 0; b < 32; b++) begin
            wr(OFF_SCRATCH, 32'h1 << b);
            rd(OFF_SCRATCH, r); chk("R3 scratch walk", r, 32'h1 << b);
        end
        wr(OFF_SCRATCH, 32'hA5A5_5A5A);
        repeat (50) @(negedge clk);
        rd(OFF_SCRATCH, r); chk("R3 scratch hold", r, 32'hA5A5_5A5A);

        // R4 wrap with compares at 5: no compare flag
        wr(OFF_DIVIDER, 100);
        wr(OFF_CMP_A, 5);
        wr(OFF_CMP_B, 5);
        wr(OFF_STATUS, 32'h13);
        wr(OFF_COUNT, 32'hFFFF_FFFF);
        wr(OFF_DIVIDER, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(OFF_COUNT, r);  chk("R4 wrap to zero", r, 0);
        rd(OFF_STATUS, r);
        chk("R4 no compare flag on wrap", r & 32'h11, 0);
        chk("R5 tick flag", 32'(r[1]), 1);

        // R5/R8 compare A with its enable set (bit 2)
        wr(OFF_DIVIDER, 100);
        wr(OFF_COUNT, 10);
        wr(OFF_STATUS, 32'h13 | 32'h04);
        wr(OFF_CMP_A, 13);
        wr(OFF_DIVIDER, 0);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            rd(OFF_STATUS, r);
            if (r[0]) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk("R5 compare A flag", 32'(seen), 1);
        rd(OFF_COUNT, r);  chk("R5 flag A with count on match", r, 13);
        chk("R8 irq one cycle late", 32'(irq), 0);
        @(negedge clk);
        chk("R8 irq from compare A", 32'(irq), 1);

        // R5/R6/R8 compare B with enable clear first
        wr(OFF_DIVIDER, 100);
        wr(OFF_STATUS, 32'h13);
        wr(OFF_COUNT, 20);
        wr(OFF_CMP_B, 23);
        wr(OFF_DIVIDER, 0);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            rd(OFF_STATUS, r);
            if (r[4]) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk("R5 compare B flag", 32'(seen), 1);
        rd(OFF_COUNT, r);  chk("R5 flag B with count on match", r, 23);
        repeat (2) @(negedge clk);
        chk("R8 masked flag gives no irq", 32'(irq), 0);
        wr(OFF_STATUS, 32'h40);
        rd(OFF_STATUS, r); chk("R6 zero write keeps flag", 32'(r[4]), 1);
        @(negedge clk);
        chk("R8 irq after enable B", 32'(irq), 1);
        wr(OFF_STATUS, 32'h50);
        rd(OFF_STATUS, r); chk("R6 one write clears flag B", 32'(r[4]), 0);
        @(negedge clk);
        chk("R8 irq drops after clear", 32'(irq), 0);

        // R7 enable bits read back, reserved bits read zero
        wr(OFF_STATUS, 32'h4C);
        rd(OFF_STATUS, r); chk("R7 enables stored", r & 32'h4C, 32'h4C);
        wr(OFF_STATUS, 32'hFFFF_FFA0);
        rd(OFF_STATUS, r); chk("R7 reserved bits zero", r & ~32'h13, 0);

        // R8 tick interrupt through enable bit 3
        wr(OFF_STATUS, 32'h08);
        repeat (4) @(negedge clk);
        chk("R8 tick irq", 32'(irq), 1);
        wr(OFF_STATUS, 32'h00);
        repeat (2) @(negedge clk);
        chk("R8 tick irq masked", 32'(irq), 0);

        // R6 clear away from a tick edge, then on a tick edge (period 6)
        wr(OFF_DIVIDER, 0);
        repeat (4) @(negedge clk);
        wr(OFF_DIVIDER, 2);
        repeat (4) @(negedge clk);
        wr(OFF_STATUS, 32'h02);
        rd(OFF_STATUS, r); chk("R6 clear off tick", 32'(r[1]), 0);
        wr(OFF_DIVIDER, 2);
        repeat (5) @(negedge clk);
        wr(OFF_STATUS, 32'h02);
        rd(OFF_STATUS, r); chk("R6 set wins on tick", 32'(r[1]), 1);

        // R9 clock select
        wr(OFF_CLKSEL, 3);
        rd(OFF_CLKSEL, r); chk("R9 clksel 3", r, 3);
        wr(OFF_CLKSEL, 32'hFFFF_FFF1);
        rd(OFF_CLKSEL, r); chk("R9 clksel low bits", r, 1);

        // R10 unmapped offsets
        wr(OFF_SCRATCH, 32'hCAFE_F00D);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(OFF_SCRATCH, r); chk("R10 scratch untouched", r, 32'hCAFE_F00D);
        rd(OFF_CLKSEL, r);  chk("R10 clksel untouched", r, 1);
        rd(8'h14, r); chk("R10 read 0x14", r, 0);
        rd(8'h10, r); chk("R10 read 0x10", r, 0);
        rd(8'h44, r); chk("R10 read 0x44", r, 0);
        rd(8'hFC, r); chk("R10 read 0xFC", r, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule